// File: doc/BRIEF.md
# Capacitive Touch Pad Scanner

The scanner reads a small group of capacitive touch pads. Each pad sits on a tristate I/O pin that has an external pull-up resistor and a capacitor to ground. The scanner repeats the same sequence for every scan. It drives all pins low long enough to empty the capacitors. It then releases the pins and watches for the first pin whose synchronised input goes high. Exactly one clock after that, it samples every pin. A finger adds capacitance to its pad and delays that pad's rise, so a pin that is still low at the sample is reported as touched.

A pad that turns from untouched to touched produces a single-cycle press pulse. The touch vector is held between scans. A scan in which no pin rises within a bounded wait is abandoned and leaves the previous result in place. The pin driver is built from one output-enable bit per pad and a drive value that is always low.

Top module: `cap_touch_scan`

## Requirements
- R1: While rst_ni is low, touch_o and press_o are all zero and every bit of pad_oe_o is 1, so the pads are being discharged.
- R2: In every scan, all pad_oe_o bits are asserted together for exactly DISCH_CYC consecutive cycles, and pad_do_o is 0 at all times.
- R3: Between two discharge phases the pins stay released (pad_oe_o all 0) for at least GAP_CYC+2 cycles: at least one wait cycle, one sample cycle and the idle gap.
- R4: Pad inputs pass through a two-flop synchroniser. A pad is touched when its synchronised input is still low one cycle after the first synchronised high. Seen at the pins, a pad that rises two or more cycles after the earliest pad is touched, and one that rises at most one cycle after it is not.
- R5: When every pad is high at the sample, no pad is reported. This includes the case where all pads are touched and rise together.
- R6: Any combination of up to N_PADS-1 touched pads is reported exactly in touch_o, with bit i belonging to pad i.
- R7: press_o[i] pulses for one cycle when touch_o[i] goes from 0 to 1 and never on a 1-to-0 change.
- R8: A touch state that stays the same across repeated scans produces no further press pulses.
- R9: If no synchronised pad input rises within TMO_CYC wait cycles, the scan is abandoned. touch_o keeps its value, no press is issued, and the release period lasts exactly TMO_CYC+GAP_CYC cycles before the next discharge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pad_i | input | N_PADS | Pad pin input levels |
| pad_oe_o | output | N_PADS | Per-pad output enable; 1 drives the pin |
| pad_do_o | output | N_PADS | Per-pad drive value, always 0 |
| touch_o | output | N_PADS | Touch vector from the last completed scan |
| press_o | output | N_PADS | One-cycle pulse per pad on a new touch |

## Verification
A sequencer stuck in the wrong state, or a counter off by one, shows up at the pins within one scan. It appears as a discharge or release run of the wrong length on pad_oe_o, and the bench measures the length of every run. A wrong sample point shows within one scan as a misclassified pad in the boundary pattern, where pads rise one and two cycles after the earliest pad. A corrupted previous-touch register shows as a missing, extra or repeated press pulse in the scan after the pattern changes.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [1:0] {
    ST_DISCH  = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_GAP    = 2'd3
  } scan_st_e;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cts_seq.sv
module cts_seq
  import cts_pkg::*;
#(
  parameter int DISCH_CYC = 8,
  parameter int GAP_CYC   = 4,
  parameter int TMO_CYC   = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_hi_i,
  output logic disch_o,
  output logic sample_o
);
  localparam int MAX_A = (DISCH_CYC > GAP_CYC) ? DISCH_CYC : GAP_CYC;
  localparam int MAX_C = (MAX_A > TMO_CYC) ? MAX_A : TMO_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  scan_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + CW'(1);
    unique case (st_q)
      ST_DISCH: if (cnt_q == CW'(DISCH_CYC - 1)) begin
        st_d  = ST_WAIT;
        cnt_d = '0;
      end
      ST_WAIT: begin
        if (any_hi_i) begin
          st_d  = ST_SAMPLE;
          cnt_d = '0;
        end else if (cnt_q == CW'(TMO_CYC - 1)) begin
          st_d  = ST_GAP;   // no pin rose: abandon scan
          cnt_d = '0;
        end
      end
      ST_SAMPLE: begin
        st_d  = ST_GAP;
        cnt_d = '0;
      end
      ST_GAP: if (cnt_q == CW'(GAP_CYC - 1)) begin
        st_d  = ST_DISCH;
        cnt_d = '0;
      end
      default: begin
        st_d  = ST_DISCH;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_DISCH;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign disch_o  = (st_q == ST_DISCH);
  assign sample_o = (st_q == ST_SAMPLE);

  // R2: discharge leaves only after its full hold time
  a_r2_disch_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && $past(st_q) == ST_DISCH) |-> $past(cnt_q) == CW'(DISCH_CYC - 1));

  // R4: sampling happens one cycle after the first synchronised high
  a_r4_sample_after_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SAMPLE) |-> ($past(st_q) == ST_WAIT && $past(any_hi_i)));

  // R9: an exhausted wait window goes to the gap and skips the sample
  a_r9_tmo_to_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && cnt_q == CW'(TMO_CYC - 1) && !any_hi_i) |=> (st_q == ST_GAP));
endmodule

// File: rtl/cts_eval.sv
module cts_eval #(
  parameter int N_PADS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [N_PADS-1:0] sync_i,
  output logic [N_PADS-1:0] touch_o,
  output logic [N_PADS-1:0] press_o
);
  logic [N_PADS-1:0] touch_q, press_q, touch_new;

  // low at the sample means touched; all high means none touched
  always_comb begin
    touch_new = ~sync_i;
    if (&sync_i) touch_new = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      touch_q <= '0;
      press_q <= '0;
    end else if (sample_i) begin
      touch_q <= touch_new;
      press_q <= touch_new & ~touch_q;
    end else begin
      press_q <= '0;
    end
  end

  assign touch_o = touch_q;
  assign press_o = press_q;

  // R7: pulse only on 0->1 of the touch bit
  a_r7_press_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|press_q) |-> (((press_q & $past(touch_q)) == '0) && ((press_q & ~touch_q) == '0)));

  // R8: pulses come only from a sample
  a_r8_press_from_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|press_q) |-> $past(sample_i));

  // R9: result held when no sample is taken
  a_r9_hold_no_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(touch_q));
endmodule

// File: rtl/cap_touch_scan.sv
module cap_touch_scan #(
  parameter int N_PADS    = 4,
  parameter int DISCH_CYC = 8,
  parameter int GAP_CYC   = 4,
  parameter int TMO_CYC   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PADS-1:0] pad_i,
  output logic [N_PADS-1:0] pad_oe_o,
  output logic [N_PADS-1:0] pad_do_o,
  output logic [N_PADS-1:0] touch_o,
  output logic [N_PADS-1:0] press_o
);
  logic [N_PADS-1:0] pad_s;
  logic              disch, sample;

  cts_sync #(.WIDTH(N_PADS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_s)
  );

  cts_seq #(
    .DISCH_CYC(DISCH_CYC),
    .GAP_CYC  (GAP_CYC),
    .TMO_CYC  (TMO_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .any_hi_i(|pad_s),
    .disch_o (disch),
    .sample_o(sample)
  );

  cts_eval #(.N_PADS(N_PADS)) u_eval (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample),
    .sync_i  (pad_s),
    .touch_o (touch_o),
    .press_o (press_o)
  );

  assign pad_oe_o = {N_PADS{disch}};
  assign pad_do_o = '0;
endmodule

// File: tb/cap_touch_scan_test.sv
module cap_touch_scan_test;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 4;
  localparam int DISCH  = 8;
  localparam int GAP    = 4;
  localparam int TMO    = 64;
  localparam int NEVER  = 10000;
  localparam int SETTLE = 500;

  typedef struct {
    logic [N-1:0] touch;
    logic [N-1:0] press;
    bit           tmo;
    string        req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] oe, dout, touch, press;

  int checks = 0, fails = 0;
  bit done = 0;
  int dly[N];
  int mcnt[N];
  int pcnt[N];
  exp_t sb_q[$];
  logic [N-1:0] prev_touch = '0;

  int hi_run = 0, lo_run = 0, last_lo = 0;
  bit prev_oe = 1'b1, seen_first = 0;
  int disch_bad = 0, rel_bad = 0, split_bad = 0, do_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_touch_scan #(
    .N_PADS(N), .DISCH_CYC(DISCH), .GAP_CYC(GAP), .TMO_CYC(TMO)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad_in),
    .pad_oe_o(oe), .pad_do_o(dout), .touch_o(touch), .press_o(press)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // pad model: held at 0 while driven, rises dly cycles after release
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (oe[i]) begin
        mcnt[i] = 0;
        pad_in[i] = 1'b0;
      end else begin
        mcnt[i]++;
        pad_in[i] = (mcnt[i] >= dly[i]);
      end
    end
  end

  // monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (oe != '0 && oe != '1) split_bad++;
      if (dout != '0) do_bad++;
      for (int i = 0; i < N; i++) if (press[i]) pcnt[i]++;
      if (oe[0]) begin
        if (!prev_oe) begin
          last_lo = lo_run;
          if (lo_run < GAP + 2) rel_bad++;
        end
        hi_run++;
        lo_run = 0;
      end else begin
        if (prev_oe) begin
          if (seen_first && hi_run != DISCH) disch_bad++;
          seen_first = 1;
        end
        lo_run++;
        hi_run = 0;
      end
      prev_oe = oe[0];
      if (sb_q.size() > 0) begin
        exp_t e;
        logic [N-1:0] pm;
        bit multi;
        e = sb_q.pop_front();
        pm = '0;
        multi = 0;
        for (int i = 0; i < N; i++) begin
          pm[i] = (pcnt[i] != 0);
          if (pcnt[i] > 1) multi = 1;
          pcnt[i] = 0;
        end
        chk(touch == e.touch, e.req, "touch_o", 32'(touch), 32'(e.touch));
        chk(pm == e.press && !multi, e.req, "press pulses", 32'(pm) | (multi ? 32'h100 : 32'h0), 32'(e.press));
        if (e.tmo) chk(last_lo == TMO + GAP, "R9", "release length", 32'(last_lo), 32'(TMO + GAP));
      end
    end
  end

  task automatic run_case(input int d0, input int d1, input int d2, input int d3,
                          input string req, input bit tmo);
    exp_t e;
    int mn;
    logic [N-1:0] t;
    @(negedge clk);
    while (!oe[0]) @(negedge clk);
    dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
    repeat (SETTLE) @(negedge clk);
    mn = NEVER;
    for (int i = 0; i < N; i++) if (dly[i] < mn) mn = dly[i];
    if (mn >= NEVER) t = prev_touch;
    else for (int i = 0; i < N; i++) t[i] = (dly[i] >= mn + 2);
    e.touch = t;
    e.press = t & ~prev_touch;
    e.tmo   = tmo;
    e.req   = req;
    prev_touch = t;
    sb_q.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin dly[i] = 5; mcnt[i] = 0; pcnt[i] = 0; end
    repeat (3) @(negedge clk);
    chk(touch == '0, "R1", "reset touch_o", 32'(touch), 0);
    chk(press == '0, "R1", "reset press_o", 32'(press), 0);
    chk(oe == '1, "R1", "reset pad_oe_o", 32'(oe), 32'hf);
    chk(dout == '0, "R1", "reset pad_do_o", 32'(dout), 0);
    rst_n = 1'b1;

    run_case(5, 5, 5, 5, "R4", 0);           // nothing touched
    run_case(9, 5, 5, 5, "R4", 0);           // pad0 touched
    run_case(9, 5, 5, 5, "R8", 0);           // steady, no new pulse
    run_case(9, 9, 9, 5, "R6", 0);           // three touched
    run_case(9, 9, 9, 9, "R5", 0);           // all four: none reported, releases silent (R7)
    run_case(5, 6, 7, 20, "R4", 0);          // boundary: +1 untouched, +2 touched
    run_case(5, 5, 9, 5, "R7", 0);           // pad3 released, pad2 held: no pulse
    run_case(NEVER, NEVER, NEVER, NEVER, "R9", 1);
    run_case(5, 9, 5, 5, "R9", 0);           // recovery after timeout

    chk(disch_bad == 0, "R2", "bad discharge runs", 32'(disch_bad), 0);
    chk(split_bad == 0 && do_bad == 0, "R2", "oe split or nonzero drive", 32'(split_bad + do_bad), 0);
    chk(rel_bad == 0, "R3", "short release runs", 32'(rel_bad), 0);
    finish_run();
  end
endmodule